// File: doc/BRIEF.md
# Power-Up Strap Level Decoder

This block reads the setting of a resistor-divider strap pin once per power cycle. After the supply-good signal rises, the first digitized sample of the pin voltage is sorted into one of nine voltage bands. Eight of the bands are valid and map to a 3-bit configuration word. The ninth band, at the top of the range, is reserved and is reported as an error.

The latched word is split into two fields:
- a gain-mode select: a low step or a high step;
- a carrier-frequency multiplier: 4, 5, 6 or 8 times the sample-synchronous reference rate.

Once a sample has been taken, further samples are ignored until power-good falls and rises again. The amplifier therefore keeps the strap setting it saw at start-up, even if the pin voltage drifts or is changed afterwards.

The band edges are ADC code constants derived for a 10-bit converter with a 7.0 V full scale. Each edge sits midway between the top of one voltage band and the bottom of the next.

Top module: `strap_level_decoder`

## Requirements
- R1: After synchronous reset, `cfg_valid` = 0, `cfg_err` = 0, `cfg_word` = 0, `gain_hi` = 0 and `freq_mult` = 4.
- R2: A captured ADC code maps to `cfg_word` as follows: below 113 gives 0; 113–226 gives 1; 227–338 gives 2; 339–452 gives 3; 453–566 gives 4; 567–680 gives 5; 681–793 gives 6; 794–964 gives 7.
- R3: A captured code of 965 or above is reserved. It sets `cfg_err` = 1, keeps `cfg_valid` = 0, and holds the code-0 outputs (`cfg_word` = 0, `gain_hi` = 0, `freq_mult` = 4). `cfg_valid` and `cfg_err` are never both 1.
- R4: `gain_hi` is 0 for words 0–3 (low gain) and 1 for words 4–7 (high gain).
- R5: `freq_mult` is 4, 5, 6 or 8 for `cfg_word[1:0]` = 0, 1, 2 or 3 respectively. No other multiplier value ever appears.
- R6: Once a sample has been captured, later `adc_valid` pulses with any code leave every output unchanged for as long as `pwr_good` stays high.
- R7: One cycle after a clock edge with `pwr_good` low, the outputs return to their reset values. After `pwr_good` rises again, the next sample is captured afresh.
- R8: A sample is captured only if `adc_valid` is high at an edge at least one cycle after `pwr_good` was first seen high. Samples taken while `pwr_good` is low are ignored. The outputs change on the cycle after the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-good; a low level clears and re-arms capture |
| adc_code | input | 10 | Digitized strap pin voltage |
| adc_valid | input | 1 | Strobe marking `adc_code` as a fresh sample |
| cfg_word | output | 3 | Latched configuration word |
| gain_hi | output | 1 | 1 selects the high gain step |
| freq_mult | output | 4 | Carrier multiplier: 4, 5, 6 or 8 |
| cfg_err | output | 1 | Reserved band was captured |
| cfg_valid | output | 1 | A valid configuration is latched |

## Verification
The main function is driven with both codes on each side of every band edge, plus the minimum and maximum codes. A threshold that is off by one code therefore changes the decoded word, and a swapped gain or multiplier field shows up immediately.

After each capture, a second sample from a different band is presented. This tells true latching apart from a transparent decode.

Directed cases separate three behaviours:
- a strobe while power-good is low must be ignored;
- a power-good drop must clear the outputs;
- a fresh capture after power-good returns must decode the new value.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int ADC_W      = 10;
    localparam int WORD_W     = 3;
    localparam int NUM_BANDS  = 1 << WORD_W;
    localparam int MULT_W     = 4;
    localparam int FS_MV      = 7000;
    localparam int ADC_MAX    = (1 << ADC_W) - 1;

    typedef enum logic { GAIN_LO = 1'b0, GAIN_HI = 1'b1 } gain_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] code;
        logic              reserved;
    } band_t;

    typedef struct packed {
        gain_e             gain;
        logic [MULT_W-1:0] mult;
    } fields_t;

    // Upper edge (mV) of band k, midway between one band's top and the next band's bottom.
    function automatic int band_edge_mv(input int k);
        case (k)
            0: return 775;
            1: return 1555;
            2: return 2325;
            3: return 3105;
            4: return 3885;
            5: return 4665;
            6: return 5435;
            default: return 6605;
        endcase
    endfunction

    // First ADC code that belongs to band k+1.
    function automatic int band_edge_code(input int k);
        return (band_edge_mv(k) * ADC_MAX) / FS_MV;
    endfunction
endpackage

// File: rtl/strap_band_classifier.sv
module strap_band_classifier
    import strap_pkg::*;
(
    input  logic [ADC_W-1:0] adc_code,
    output band_t            band
);
    logic [NUM_BANDS-1:0] above;

    for (genvar k = 0; k < NUM_BANDS; k++) begin : g_cmp
        localparam int EDGE = band_edge_code(k);
        assign above[k] = (int'(adc_code) >= EDGE);
    end

    always_comb begin
        band.code     = '0;
        band.reserved = above[NUM_BANDS-1];
        for (int k = 0; k < NUM_BANDS-1; k++) begin
            if (above[k]) band.code = WORD_W'(k + 1);
        end
        if (band.reserved) band.code = '0;
    end
endmodule

// File: rtl/strap_field_decoder.sv
module strap_field_decoder
    import strap_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fields_t           fields
);
    always_comb begin
        fields.gain = word[WORD_W-1] ? GAIN_HI : GAIN_LO;
        case (word[1:0])
            2'd0:    fields.mult = MULT_W'(4);
            2'd1:    fields.mult = MULT_W'(5);
            2'd2:    fields.mult = MULT_W'(6);
            default: fields.mult = MULT_W'(8);
        endcase
    end
endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              sample_valid,
    input  band_t             band,
    output logic [WORD_W-1:0] word_q,
    output logic              valid_q,
    output logic              err_q
);
    cap_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            state_q <= ST_OFF;
            word_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_OFF:   state_q <= ST_ARMED;
                ST_ARMED: begin
                    if (sample_valid) begin
                        state_q <= ST_LOCKED;
                        word_q  <= band.reserved ? '0 : band.code;
                        valid_q <= !band.reserved;
                        err_q   <= band.reserved;
                    end
                end
                default:  state_q <= ST_LOCKED;
            endcase
        end
    end
endmodule

// File: rtl/strap_level_decoder.sv
module strap_level_decoder
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic [ADC_W-1:0]  adc_code,
    input  logic              adc_valid,
    output logic [WORD_W-1:0] cfg_word,
    output logic              gain_hi,
    output logic [MULT_W-1:0] freq_mult,
    output logic              cfg_err,
    output logic              cfg_valid
);
    band_t   band;
    fields_t fields;

    strap_band_classifier u_class (
        .adc_code (adc_code),
        .band     (band)
    );

    strap_capture_ctrl u_cap (
        .clk          (clk),
        .rst          (rst),
        .pwr_good     (pwr_good),
        .sample_valid (adc_valid),
        .band         (band),
        .word_q       (cfg_word),
        .valid_q      (cfg_valid),
        .err_q        (cfg_err)
    );

    strap_field_decoder u_fields (
        .word   (cfg_word),
        .fields (fields)
    );

    assign gain_hi   = (fields.gain == GAIN_HI);
    assign freq_mult = fields.mult;
endmodule

// File: rtl/strap_level_decoder_chk.sv
module strap_level_decoder_chk
    import strap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pwr_good,
    input logic              adc_valid,
    input logic [WORD_W-1:0] cfg_word,
    input logic              gain_hi,
    input logic [MULT_W-1:0] freq_mult,
    input logic              cfg_err,
    input logic              cfg_valid
);
    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cfg_valid && cfg_err)); // R3

    AST_RESERVED_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (cfg_word == '0 && !gain_hi && freq_mult == MULT_W'(4))); // R3

    AST_MULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        freq_mult == MULT_W'(4) || freq_mult == MULT_W'(5) ||
        freq_mult == MULT_W'(6) || freq_mult == MULT_W'(8)); // R5

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && (cfg_valid || cfg_err)) |=>
        ($stable(cfg_word) && $stable(cfg_valid) && $stable(cfg_err))); // R6

    AST_PG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!cfg_valid && !cfg_err && cfg_word == '0)); // R7

    AST_CAPTURE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> ($past(adc_valid) && $past(pwr_good))); // R8
endmodule

bind strap_level_decoder strap_level_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .adc_valid (adc_valid),
    .cfg_word  (cfg_word),
    .gain_hi   (gain_hi),
    .freq_mult (freq_mult),
    .cfg_err   (cfg_err),
    .cfg_valid (cfg_valid)
);

// File: tb/strap_level_decoder_tb_top.sv
module strap_level_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_good = 1'b0;
    logic [9:0] adc_code = '0;
    logic       adc_valid = 1'b0;
    logic [2:0] cfg_word;
    logic       gain_hi;
    logic [3:0] freq_mult;
    logic       cfg_err;
    logic       cfg_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    strap_level_decoder dut_i (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .adc_code(adc_code),
        .adc_valid(adc_valid), .cfg_word(cfg_word), .gain_hi(gain_hi),
        .freq_mult(freq_mult), .cfg_err(cfg_err), .cfg_valid(cfg_valid)
    );

    // {adc code, expected word, expected reserved}
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        {10'd0,    3'd0, 1'b0}, {10'd112,  3'd0, 1'b0},
        {10'd113,  3'd1, 1'b0}, {10'd226,  3'd1, 1'b0},
        {10'd227,  3'd2, 1'b0}, {10'd338,  3'd2, 1'b0},
        {10'd339,  3'd3, 1'b0}, {10'd452,  3'd3, 1'b0},
        {10'd453,  3'd4, 1'b0}, {10'd566,  3'd4, 1'b0},
        {10'd567,  3'd5, 1'b0}, {10'd680,  3'd5, 1'b0},
        {10'd681,  3'd6, 1'b0}, {10'd793,  3'd6, 1'b0},
        {10'd794,  3'd7, 1'b0}, {10'd964,  3'd7, 1'b0},
        {10'd965,  3'd0, 1'b1}, {10'd1023, 3'd0, 1'b1}
    };

    function automatic logic [3:0] exp_mult(input logic [1:0] lo);
        case (lo)
            2'd0: return 4'd4;
            2'd1: return 4'd5;
            2'd2: return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    task automatic check_out(input string req, input logic [2:0] w, input logic v, input logic e);
        logic [2:0] ew;
        logic [3:0] em;
        logic       eg;
        ew = e ? 3'd0 : w;
        eg = ew[2];
        em = exp_mult(ew[1:0]);
        checks++;
        if (cfg_word !== ew || cfg_valid !== v || cfg_err !== e ||
            gain_hi !== eg || freq_mult !== em) begin
            failures++;
            $display("FAIL %s: actual word=%0d valid=%0b err=%0b gain=%0b mult=%0d expected word=%0d valid=%0b err=%0b gain=%0b mult=%0d",
                     req, cfg_word, cfg_valid, cfg_err, gain_hi, freq_mult,
                     ew, v, e, eg, em);
        end
    endtask

    task automatic power_cycle();
        @(negedge clk) pwr_good = 1'b0;
        @(negedge clk);
        @(negedge clk) pwr_good = 1'b1;
        @(negedge clk);
    endtask

    task automatic sample(input logic [9:0] code);
        adc_code = code; adc_valid = 1'b1;
        @(negedge clk) adc_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1", 3'd0, 1'b0, 1'b0);
        rst = 1'b0;

        // R8: strobe while power is down is ignored
        @(negedge clk) sample(10'd500);
        check_out("R8", 3'd0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [9:0] c;
            logic [2:0] w;
            logic       r;
            {c, w, r} = VEC[i];
            power_cycle();
            sample(c);
            check_out(r ? "R3" : "R2/R4/R5", w, !r, r);
            sample(c ^ 10'h2AA);
            @(negedge clk);
            check_out("R6", w, !r, r);
        end

        // R7: drop of power-good clears outputs one cycle later
        power_cycle();
        sample(10'd700);
        check_out("R2", 3'd6, 1'b1, 1'b0);
        pwr_good = 1'b0;
        @(negedge clk);
        check_out("R7", 3'd0, 1'b0, 1'b0);
        pwr_good = 1'b1;
        @(negedge clk);
        sample(10'd150);
        check_out("R7", 3'd1, 1'b1, 1'b0);

        // R8: strobe on the same edge that first sees power-good is ignored
        @(negedge clk) pwr_good = 1'b0;
        @(negedge clk) pwr_good = 1'b1;
        sample(10'd900);
        check_out("R8", 3'd0, 1'b0, 1'b0);
        sample(10'd400);
        check_out("R8", 3'd3, 1'b1, 1'b0);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule